// File: doc/BRIEF.md
# Depth-Stencil Interleave Box Walker

This sequencer moves a three-dimensional box of texels between a packed linear staging buffer and a surface whose depth and stencil values live in two separately addressed planes. In the unpack direction it fetches one depth word and one stencil byte per texel and writes the merged, packed texel to staging one byte at a time. In the pack direction it gathers the packed texel from staging and splits it back, writing the used depth bytes to the depth plane and the stencil byte to the stencil plane. A third format handles a surface that holds only stencil, with one byte per texel.

Plane addresses come from two address generator instances. Each one turns a plane origin, a per-slice row offset, a pitch and the walker's column, row and slice counters into a byte address. The tiling of each plane lies outside this block. Each of the three memory ports uses a request/acknowledge pair. A request stays up, with its address and data steady, until the acknowledge arrives. All configuration inputs must hold steady while `busy` is high.

Top module: `ds_box_walker`

## Requirements
- R1: After reset `busy`, `done`, `dreq`, `sreq` and `stg_req` are all low.
- R2: Format code 0 (24-bit depth + stencil, 4-byte texel) in unpack (`dir`=0): staging bytes 0..2 of each texel hold depth bytes 0..2, and byte 3 holds the stencil byte.
- R3: Format code 1 (32-bit depth + stencil, 8-byte texel) in unpack: staging bytes 0..3 hold depth bytes 0..3, byte 4 holds the stencil byte, and bytes 5..7 are written as zero.
- R4: Format code 2 (stencil only) moves one byte per texel between the stencil plane and staging, and it never raises `dreq`.
- R5: Texels are visited with the slice outermost, then the row, then the column. The staging byte k of texel (c,r,s) is at s*`stg_layer_stride` + r*`stg_row_stride` + c*T + k, where T is the texel size in bytes.
- R6: The depth plane address is (`d_org_y` + s*`d_slice_dy` + r)*`d_pitch` + `d_org_x` + 4c. The stencil address is (`s_org_y` + s*`s_slice_dy` + r)*`s_pitch` + `s_org_x` + c.
- R7: Format 0 in pack (`dir`=1): depth writes use byte enable 4'b0111 with staging bytes 0..2, the stencil plane receives staging byte 3, and depth byte 3 is left unchanged.
- R8: Format 1 in pack: depth writes use byte enable 4'b1111 with staging bytes 0..3, and the stencil plane receives staging byte 4.
- R9: A start with zero width, height or depth raises `done` on the next cycle and issues no memory request.
- R10: Any raised request (`dreq`, `sreq`, `stg_req`) stays high with a stable address until it is acknowledged.
- R11: `done` lasts exactly one cycle. A staging request is never raised while a plane request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin a walk (accepted while idle) |
| dir | input | 1 | 0 unpack planes to staging, 1 pack staging to planes |
| fmt | input | 2 | 0 = 24-bit depth + stencil, 1 = 32-bit depth + stencil, 2 = stencil only |
| box_w | input | CW | Box width in texels |
| box_h | input | CW | Box height in rows |
| box_d | input | CW | Box depth in slices |
| d_org_x | input | CW | Depth plane byte x origin |
| d_org_y | input | CW | Depth plane row origin |
| d_slice_dy | input | CW | Depth plane rows per slice step |
| d_pitch | input | AW | Depth plane bytes per row |
| s_org_x | input | CW | Stencil plane x origin |
| s_org_y | input | CW | Stencil plane row origin |
| s_slice_dy | input | CW | Stencil plane rows per slice step |
| s_pitch | input | AW | Stencil plane bytes per row |
| stg_row_stride | input | AW | Staging bytes per row |
| stg_layer_stride | input | AW | Staging bytes per slice |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| dreq | output | 1 | Depth plane request |
| dwe | output | 1 | Depth request is a write |
| dbe | output | 4 | Depth write byte enables |
| daddr | output | AW | Depth plane byte address |
| dwdata | output | 32 | Depth write data, byte 0 in bits 7:0 |
| dack | input | 1 | Depth request acknowledge |
| drdata | input | 32 | Depth read data, valid with `dack` |
| sreq | output | 1 | Stencil plane request |
| swe | output | 1 | Stencil request is a write |
| saddr | output | AW | Stencil plane byte address |
| swdata | output | 8 | Stencil write data |
| sack | input | 1 | Stencil request acknowledge |
| srdata | input | 8 | Stencil read data, valid with `sack` |
| stg_req | output | 1 | Staging byte request |
| stg_we | output | 1 | Staging request is a write |
| stg_addr | output | AW | Staging byte address |
| stg_wdata | output | 8 | Staging write byte |
| stg_ack | input | 1 | Staging acknowledge |
| stg_rdata | input | 8 | Staging read byte, valid with `stg_ack` |

## Verification
The bound checker watches the handshake rules on every cycle. It checks that requests are held with steady addresses until acknowledged, that staging and plane traffic never overlap, that `done` lasts one cycle, that a stencil-only walk never touches the depth port, and that an empty box finishes at once. Byte placement inside each packed texel, the visiting order, the address arithmetic and the untouched depth byte in 24-bit pack mode are shown only by the bench's scenarios. The bench compares every staging and plane byte against a model computed independently of the design.

// File: rtl/ds_walk_pkg.sv
package ds_walk_pkg;

  typedef enum logic [1:0] {
    FMT_D24S8 = 2'd0,
    FMT_D32S8 = 2'd1,
    FMT_S8    = 2'd2
  } ds_fmt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GATHER,
    ST_ISSUE,
    ST_WAIT,
    ST_STORE,
    ST_DONE
  } ds_state_e;

  // last byte index of a packed texel
  function automatic logic [2:0] texel_last(input ds_fmt_e f);
    case (f)
      FMT_D24S8: texel_last = 3'd3;
      FMT_D32S8: texel_last = 3'd7;
      default:   texel_last = 3'd0;
    endcase
  endfunction

  // byte position of the stencil inside a packed texel
  function automatic logic [2:0] stencil_pos(input ds_fmt_e f);
    case (f)
      FMT_D24S8: stencil_pos = 3'd3;
      FMT_D32S8: stencil_pos = 3'd4;
      default:   stencil_pos = 3'd0;
    endcase
  endfunction

  // number of depth bytes carried per texel
  function automatic logic [2:0] depth_used(input ds_fmt_e f);
    case (f)
      FMT_D24S8: depth_used = 3'd3;
      FMT_D32S8: depth_used = 3'd4;
      default:   depth_used = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/ds_box_counter.sv
module ds_box_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [CW-1:0] box_w,
  input  logic [CW-1:0] box_h,
  input  logic [CW-1:0] box_d,
  output logic [CW-1:0] col,
  output logic [CW-1:0] row,
  output logic [CW-1:0] slc,
  output logic          last
);
  logic col_end, row_end, slc_end;
  logic [CW-1:0] col_d, row_d, slc_d;

  assign col_end = (col == box_w - CW'(1));
  assign row_end = (row == box_h - CW'(1));
  assign slc_end = (slc == box_d - CW'(1));
  assign last    = col_end && row_end && slc_end;

  always_comb begin
    col_d = col;
    row_d = row;
    slc_d = slc;
    if (clr) begin
      col_d = '0;
      row_d = '0;
      slc_d = '0;
    end else if (step) begin
      if (!col_end) begin
        col_d = col + CW'(1);
      end else begin
        col_d = '0;
        if (!row_end) begin
          row_d = row + CW'(1);
        end else begin
          row_d = '0;
          slc_d = slc + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
      slc <= '0;
    end else if (clr || step) begin
      col <= col_d;
      row <= row_d;
      slc <= slc_d;
    end
  end
endmodule

// File: rtl/ds_plane_addr.sv
module ds_plane_addr #(
  parameter int CW     = 8,
  parameter int AW     = 16,
  parameter int XSHIFT = 0
) (
  input  logic [CW-1:0] org_x,
  input  logic [CW-1:0] org_y,
  input  logic [CW-1:0] slice_dy,
  input  logic [AW-1:0] pitch,
  input  logic [CW-1:0] col,
  input  logic [CW-1:0] row,
  input  logic [CW-1:0] slc,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] y_line, x_byte;

  assign y_line = AW'(org_y) + AW'(slc) * AW'(slice_dy) + AW'(row);
  assign x_byte = AW'(org_x) + (AW'(col) << XSHIFT);
  assign addr   = y_line * pitch + x_byte;
endmodule

// File: rtl/ds_box_walker.sv
module ds_box_walker
  import ds_walk_pkg::*;
#(
  parameter int CW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir,
  input  logic [1:0]    fmt,
  input  logic [CW-1:0] box_w,
  input  logic [CW-1:0] box_h,
  input  logic [CW-1:0] box_d,
  input  logic [CW-1:0] d_org_x,
  input  logic [CW-1:0] d_org_y,
  input  logic [CW-1:0] d_slice_dy,
  input  logic [AW-1:0] d_pitch,
  input  logic [CW-1:0] s_org_x,
  input  logic [CW-1:0] s_org_y,
  input  logic [CW-1:0] s_slice_dy,
  input  logic [AW-1:0] s_pitch,
  input  logic [AW-1:0] stg_row_stride,
  input  logic [AW-1:0] stg_layer_stride,
  output logic          busy,
  output logic          done,
  output logic          dreq,
  output logic          dwe,
  output logic [3:0]    dbe,
  output logic [AW-1:0] daddr,
  output logic [31:0]   dwdata,
  input  logic          dack,
  input  logic [31:0]   drdata,
  output logic          sreq,
  output logic          swe,
  output logic [AW-1:0] saddr,
  output logic [7:0]    swdata,
  input  logic          sack,
  input  logic [7:0]    srdata,
  output logic          stg_req,
  output logic          stg_we,
  output logic [AW-1:0] stg_addr,
  output logic [7:0]    stg_wdata,
  input  logic          stg_ack,
  input  logic [7:0]    stg_rdata
);
  localparam int DEPTH_XSHIFT = 2;  // 4 bytes per depth texel in the plane
  localparam int TEXEL_MAX    = 8;

  ds_fmt_e   fmt_e;
  ds_state_e state_q, state_d;

  logic [2:0]  byte_q, byte_d;
  logic        pend_d_q, pend_s_q;
  logic [31:0] dlat_q;
  logic [7:0]  slat_q;
  logic [7:0]  tbuf_q [TEXEL_MAX];

  logic [CW-1:0] col, row, slc;
  logic          last, cnt_clr, cnt_step;
  logic          zero_box, use_depth, planes_done;
  logic [2:0]    t_last, s_pos, d_used;

  assign fmt_e     = ds_fmt_e'(fmt);
  assign t_last    = texel_last(fmt_e);
  assign s_pos     = stencil_pos(fmt_e);
  assign d_used    = depth_used(fmt_e);
  assign use_depth = (fmt_e != FMT_S8);
  assign zero_box  = (box_w == '0) || (box_h == '0) || (box_d == '0);
  assign planes_done = (!pend_d_q || dack) && (!pend_s_q || sack);

  // ---------------- walk counters and address generators ----------------
  ds_box_counter #(.CW(CW)) u_cnt (
    .clk, .rst_n, .clr(cnt_clr), .step(cnt_step),
    .box_w, .box_h, .box_d, .col, .row, .slc, .last
  );

  ds_plane_addr #(.CW(CW), .AW(AW), .XSHIFT(DEPTH_XSHIFT)) u_daddr (
    .org_x(d_org_x), .org_y(d_org_y), .slice_dy(d_slice_dy), .pitch(d_pitch),
    .col, .row, .slc, .addr(daddr)
  );

  ds_plane_addr #(.CW(CW), .AW(AW), .XSHIFT(0)) u_saddr (
    .org_x(s_org_x), .org_y(s_org_y), .slice_dy(s_slice_dy), .pitch(s_pitch),
    .col, .row, .slc, .addr(saddr)
  );

  // ---------------- next state ----------------
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start) state_d = zero_box ? ST_DONE : (dir ? ST_GATHER : ST_ISSUE);
      ST_GATHER: if (stg_ack && byte_q == s_pos) state_d = ST_ISSUE;
      ST_ISSUE:  state_d = ST_WAIT;
      ST_WAIT:   if (planes_done) state_d = !dir ? ST_STORE : (last ? ST_DONE : ST_GATHER);
      ST_STORE:  if (stg_ack && byte_q == t_last) state_d = last ? ST_DONE : ST_ISSUE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign cnt_clr  = (state_q == ST_IDLE) && start;
  assign cnt_step = ((state_q == ST_WAIT) && planes_done && dir) ||
                    ((state_q == ST_STORE) && stg_ack && byte_q == t_last);

  always_comb begin
    byte_d = '0;
    if (state_q == ST_GATHER || state_q == ST_STORE)
      byte_d = stg_ack ? byte_q + 3'd1 : byte_q;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      byte_q   <= '0;
      pend_d_q <= 1'b0;
      pend_s_q <= 1'b0;
    end else begin
      state_q <= state_d;
      byte_q  <= byte_d;
      if (state_q == ST_ISSUE) begin
        pend_d_q <= use_depth;
        pend_s_q <= 1'b1;
      end else begin
        if (dack) pend_d_q <= 1'b0;
        if (sack) pend_s_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlat_q <= '0;
      slat_q <= '0;
    end else begin
      if (pend_d_q && dack && !dir) dlat_q <= drdata;
      if (pend_s_q && sack && !dir) slat_q <= srdata;
    end
  end

  for (genvar gi = 0; gi < TEXEL_MAX; gi++) begin : g_tbuf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tbuf_q[gi] <= '0;
      else if (state_q == ST_GATHER && stg_ack && byte_q == 3'(gi))
        tbuf_q[gi] <= stg_rdata;
    end
  end

  // ---------------- outputs ----------------
  assign busy   = (state_q != ST_IDLE);
  assign done   = (state_q == ST_DONE);
  assign dreq   = pend_d_q;
  assign sreq   = pend_s_q;
  assign dwe    = dir;
  assign swe    = dir;
  assign dbe    = (fmt_e == FMT_D24S8) ? 4'b0111 : 4'b1111;
  assign dwdata = {tbuf_q[3], tbuf_q[2], tbuf_q[1], tbuf_q[0]};
  assign swdata = tbuf_q[s_pos];

  assign stg_req  = (state_q == ST_GATHER) || (state_q == ST_STORE);
  assign stg_we   = (state_q == ST_STORE);
  assign stg_addr = AW'(slc) * stg_layer_stride + AW'(row) * stg_row_stride +
                    AW'(col) * AW'({1'b0, t_last} + 4'd1) + AW'(byte_q);

  always_comb begin
    if (byte_q < d_used)     stg_wdata = dlat_q[{byte_q[1:0], 3'b000} +: 8];
    else if (byte_q == s_pos) stg_wdata = slat_q;
    else                      stg_wdata = 8'h00;
  end
endmodule

// File: rtl/ds_box_walker_chk.sv
module ds_box_walker_chk #(
  parameter int CW = 8,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    fmt,
  input logic [CW-1:0] box_w,
  input logic [CW-1:0] box_h,
  input logic [CW-1:0] box_d,
  input logic          busy,
  input logic          done,
  input logic          dreq,
  input logic          dack,
  input logic [AW-1:0] daddr,
  input logic          sreq,
  input logic          sack,
  input logic [AW-1:0] saddr,
  input logic          stg_req,
  input logic          stg_ack,
  input logic [AW-1:0] stg_addr
);
  a_r4_no_depth_in_s8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fmt == 2'd2) |-> !dreq);

  a_r9_zero_box_done: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (box_w == '0 || box_h == '0 || box_d == '0)) |=> (done && !dreq && !sreq && !stg_req));

  a_r10_dreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && !dack) |=> (dreq && $stable(daddr)));

  a_r10_sreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sreq && !sack) |=> (sreq && $stable(saddr)));

  a_r10_stg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_req && !stg_ack) |=> (stg_req && $stable(stg_addr)));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(stg_req && (dreq || sreq)));
endmodule

bind ds_box_walker ds_box_walker_chk #(.CW(CW), .AW(AW)) u_chk (.*);

// File: tb/ds_box_walker_tb.sv
`timescale 1ns/1ps
module ds_box_walker_tb;
  localparam int CW = 8;
  localparam int AW = 16;
  localparam int DSZ = 2048;
  localparam int SSZ = 512;
  localparam int GSZ = 512;
  localparam int DPITCH = 64;
  localparam int SPITCH = 16;
  localparam int DSDY = 6;
  localparam int SSDY = 5;

  // {fmt, dir, w, h, d, d_org_x, d_org_y, s_org_x, s_org_y}
  localparam int NV = 8;
  localparam logic [58:0] TV [NV] = '{
    {2'd0, 1'b0, 8'd3, 8'd2, 8'd2, 8'd4, 8'd1, 8'd2, 8'd1},
    {2'd1, 1'b0, 8'd2, 8'd3, 8'd2, 8'd8, 8'd0, 8'd1, 8'd2},
    {2'd2, 1'b0, 8'd3, 8'd3, 8'd3, 8'd0, 8'd0, 8'd3, 8'd0},
    {2'd0, 1'b1, 8'd3, 8'd2, 8'd3, 8'd0, 8'd2, 8'd0, 8'd1},
    {2'd1, 1'b1, 8'd2, 8'd2, 8'd2, 8'd4, 8'd1, 8'd5, 8'd0},
    {2'd2, 1'b1, 8'd3, 8'd2, 8'd2, 8'd0, 8'd0, 8'd1, 8'd2},
    {2'd0, 1'b0, 8'd1, 8'd1, 8'd1, 8'd12, 8'd2, 8'd7, 8'd2},
    {2'd1, 1'b0, 8'd3, 8'd1, 8'd3, 8'd0, 8'd1, 8'd0, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic start, dir;
  logic [1:0] fmt;
  logic [CW-1:0] box_w, box_h, box_d, d_org_x, d_org_y, s_org_x, s_org_y;
  logic [CW-1:0] d_slice_dy, s_slice_dy;
  logic [AW-1:0] d_pitch, s_pitch, stg_row_stride, stg_layer_stride;
  logic busy, done;
  logic dreq, dwe, dack;
  logic [3:0] dbe;
  logic [AW-1:0] daddr;
  logic [31:0] dwdata, drdata;
  logic sreq, swe, sack;
  logic [AW-1:0] saddr;
  logic [7:0] swdata, srdata;
  logic stg_req, stg_we, stg_ack;
  logic [AW-1:0] stg_addr;
  logic [7:0] stg_wdata, stg_rdata;

  logic [7:0] dmem [DSZ];
  logic [7:0] smem [SSZ];
  logic [7:0] gmem [GSZ];
  logic [7:0] exp_d [DSZ];
  logic [7:0] exp_s [SSZ];
  logic [7:0] exp_g [GSZ];

  int tests = 0, fails = 0;
  int dcnt = 0, scnt = 0, gcnt = 0;

  always #2.5 clk = ~clk;

  ds_box_walker #(.CW(CW), .AW(AW)) u_dut (.*);

  // behavioural memories: acknowledge one cycle after a request is seen
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dack <= 1'b0; sack <= 1'b0; stg_ack <= 1'b0;
      drdata <= '0; srdata <= '0; stg_rdata <= '0;
    end else begin
      dack <= dreq && !dack;
      if (dreq && !dack) begin
        dcnt = dcnt + 1;
        if (dwe) begin
          for (int i = 0; i < 4; i++) if (dbe[i]) dmem[int'(daddr) + i] = dwdata[8*i +: 8];
        end else begin
          drdata <= {dmem[int'(daddr) + 3], dmem[int'(daddr) + 2], dmem[int'(daddr) + 1], dmem[int'(daddr)]};
        end
      end
      sack <= sreq && !sack;
      if (sreq && !sack) begin
        scnt = scnt + 1;
        if (swe) smem[int'(saddr)] = swdata;
        else srdata <= smem[int'(saddr)];
      end
      stg_ack <= stg_req && !stg_ack;
      if (stg_req && !stg_ack) begin
        gcnt = gcnt + 1;
        if (stg_we) gmem[int'(stg_addr)] = stg_wdata;
        else stg_rdata <= gmem[int'(stg_addr)];
      end
    end
  end

  task automatic fill(input int seed);
    for (int i = 0; i < DSZ; i++) begin dmem[i] = 8'(i * 13 + seed * 29 + 1); exp_d[i] = dmem[i]; end
    for (int i = 0; i < SSZ; i++) begin smem[i] = 8'((i * 7) ^ (seed * 31 + 64)); exp_s[i] = smem[i]; end
    for (int i = 0; i < GSZ; i++) begin gmem[i] = 8'(i * 5 + seed + 144); exp_g[i] = gmem[i]; end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmp_arrays(input string req, input int which);
    int bad = 0, first = -1, a = 0, e = 0, n;
    n = (which == 0) ? DSZ : (which == 1) ? SSZ : GSZ;
    for (int i = 0; i < n; i++) begin
      logic [7:0] x, y;
      x = (which == 0) ? dmem[i] : (which == 1) ? smem[i] : gmem[i];
      y = (which == 0) ? exp_d[i] : (which == 1) ? exp_s[i] : exp_g[i];
      if (x !== y) begin
        if (first < 0) begin first = i; a = int'(x); e = int'(y); end
        bad++;
      end
    end
    if (bad != 0) $display("  mismatch in %s: %0d bytes, first at %0d", req, bad, first);
    check(bad == 0, req, a, e);
  endtask

  task automatic set_cfg(input logic [58:0] v);
    int tb;
    {fmt, dir, box_w, box_h, box_d, d_org_x, d_org_y, s_org_x, s_org_y} = v;
    tb = (fmt == 2'd0) ? 4 : (fmt == 2'd1) ? 8 : 1;
    d_slice_dy = CW'(DSDY); s_slice_dy = CW'(SSDY);
    d_pitch = AW'(DPITCH); s_pitch = AW'(SPITCH);
    stg_row_stride   = AW'(int'(box_w) * tb + 3);
    stg_layer_stride = AW'((int'(box_w) * tb + 3) * int'(box_h) + 5);
  endtask

  task automatic run(output int cyc, output bit fin);
    cyc = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    fin = done;
  endtask

  // reference model computed from the requirement formulas
  task automatic model(input logic [58:0] v);
    int tb, sp, du, da, sa, ga;
    tb = (fmt == 2'd0) ? 4 : (fmt == 2'd1) ? 8 : 1;
    sp = (fmt == 2'd0) ? 3 : (fmt == 2'd1) ? 4 : 0;
    du = (fmt == 2'd0) ? 3 : (fmt == 2'd1) ? 4 : 0;
    for (int s = 0; s < int'(box_d); s++)
      for (int r = 0; r < int'(box_h); r++)
        for (int c = 0; c < int'(box_w); c++) begin
          da = (int'(d_org_y) + s * DSDY + r) * DPITCH + int'(d_org_x) + 4 * c;
          sa = (int'(s_org_y) + s * SSDY + r) * SPITCH + int'(s_org_x) + c;
          ga = s * int'(stg_layer_stride) + r * int'(stg_row_stride) + c * tb;
          if (!dir) begin
            for (int k = 0; k < tb; k++)
              exp_g[ga + k] = (k < du) ? dmem[da + k] : (k == sp) ? smem[sa] : 8'h00;
          end else begin
            for (int k = 0; k < du; k++) exp_d[da + k] = gmem[ga + k];
            exp_s[sa] = gmem[ga + sp];
          end
        end
  endtask

  function automatic string tag(input logic [1:0] f, input logic d);
    if (f == 2'd2) return d ? "R4 write R5 R6" : "R4 read R5 R6";
    if (f == 2'd0) return d ? "R7 R5 R6" : "R2 R5 R6";
    return d ? "R8 R5 R6" : "R3 R5 R6";
  endfunction

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cyc;
    bit fin;
    start = 1'b0;
    set_cfg(TV[0]);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    check(!busy && !done && !dreq && !sreq && !stg_req, "R1 reset idle",
          int'({busy, done, dreq, sreq, stg_req}), 0);

    for (int t = 0; t < NV; t++) begin
      fill(t + 1);
      set_cfg(TV[t]);
      model(TV[t]);
      dcnt = 0;
      run(cyc, fin);
      check(fin, {tag(fmt, dir), " finish"}, cyc, 0);
      cmp_arrays({tag(fmt, dir), " depth plane"}, 0);
      cmp_arrays({tag(fmt, dir), " stencil plane"}, 1);
      cmp_arrays({tag(fmt, dir), " staging"}, 2);
      if (fmt == 2'd2) check(dcnt == 0, "R4 no depth traffic", dcnt, 0);
      @(negedge clk);
    end

    // R9: zero-sized boxes finish at once with no traffic
    for (int z = 0; z < 3; z++) begin
      set_cfg(TV[z]);
      if (z == 0) box_w = '0; else if (z == 1) box_h = '0; else box_d = '0;
      dcnt = 0; scnt = 0; gcnt = 0;
      run(cyc, fin);
      check(fin && cyc == 0, "R9 zero box immediate done", cyc, 0);
      check(dcnt + scnt + gcnt == 0, "R9 zero box no traffic", dcnt + scnt + gcnt, 0);
      @(negedge clk);
      check(!done && !busy, "R11 done single pulse", int'({done, busy}), 0);
    end

    // R1 again after a mid-walk reset
    fill(9);
    set_cfg(TV[1]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy && !dreq && !sreq && !stg_req, "R1 reset mid-walk",
          int'({busy, dreq, sreq, stg_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule